// File: doc/BRIEF.md
# Ethernet transmit frame assembler

The block collects an outgoing Ethernet frame that a processor pushes into it one 32-bit word at a time, decides when the frame is ready to leave, and then emits it as a byte stream toward the MAC. The first word written into an empty buffer carries a 16-bit payload length in its low half. All later words carry the header and payload bytes, lowest byte first. The length excludes the 14-byte header. The first two bytes of the buffer (the length prefix) are never sent.

A send starts in one of two ways. In automatic mode, a coded fill threshold has been reached and the buffer already holds the whole frame. In manual mode, software pulses a request input. While a frame is being sent, the block can extend a short frame with zero bytes up to the Ethernet minimum of 60 bytes. When the last byte has been handed over, the buffer empties and a one-cycle transmit-empty event is raised. A length word that is too large is refused with a one-cycle transmit-error event. An external flush input, used when software acknowledges that error, empties the buffer.

The output stream follows valid/ready rules. Once `tx_valid_o` is high, it stays high and `tx_data_o`/`tx_last_o` stay unchanged until a cycle in which `tx_ready_i` is also high. The consumer may hold ready low for any length of time. No byte is lost or repeated. The block never needs ready to be high in order to raise valid. During a send the write port is closed and writes are dropped. Software should wait for `tx_busy_o` to fall before starting the next frame.

Top module: `enet_tx_assembler`

## Requirements
- R1: Each accepted write appends its four bytes to the buffer, least significant byte first, and the fill count grows by 4. A write that would take the fill beyond FIFO_BYTES is dropped and leaves the stored bytes unchanged.
- R2: When the buffer is empty, bits 15:0 of the written word are the payload length. A length above FIFO_BYTES-16 is refused: nothing is stored, and `tx_err_o` is high for exactly the one cycle after that write.
- R3: A frame counts as complete when the fill reaches length+16, or length+20 when `crc_auto_i` is low. This requirement is capped at FIFO_BYTES.
- R4: The threshold code resets to all ones, which disables automatic sending. With any other code T, a send starts by itself in the cycle after the fill is at least 32*T+4 and the frame is complete, and not before.
- R5: A one-cycle pulse on `tx_req_i` while idle with a non-empty buffer starts a send on the next clock edge, whether or not the frame is complete.
- R6: The emitted frame is the stored bytes from buffer offset 2 onward, length+14 bytes long and never more than FIFO_BYTES-2. Any further stored bytes, such as a trailing CRC, are not emitted.
- R7: If `pad_en_i` is high when a send starts and length+14 is below 60, the frame is extended with zero bytes to exactly 60 bytes.
- R8: After the handshake of the byte marked last, the buffer is empty and `tx_empty_o` is high for exactly one cycle.
- R9: A flush pulse while idle empties the buffer, so a following request starts nothing.
- R10: While `tx_valid_o` is high and `tx_ready_i` low, valid, data and last hold. `tx_last_o` is high only on the final byte.
- R11: While a send is in progress, data writes, requests and flushes have no effect on the buffer or on the frame being sent.
- R12: After reset no byte is offered, the block is idle, both events are low, and automatic sending is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Data word write strobe |
| wr_data_i | input | 32 | Data word (length word when buffer empty) |
| thr_we_i | input | 1 | Threshold code write strobe |
| thr_i | input | THR_W | Threshold code; all ones disables automatic send |
| crc_auto_i | input | 1 | High: CRC appended downstream, not stored in buffer |
| pad_en_i | input | 1 | Pad short frames to 60 bytes |
| tx_req_i | input | 1 | Manual send request pulse |
| flush_i | input | 1 | Empty the buffer (idle only) |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Consumer accepts the byte |
| tx_busy_o | output | 1 | A frame is being sent |
| tx_empty_o | output | 1 | One-cycle event: frame sent, buffer empty |
| tx_err_o | output | 1 | One-cycle event: length word refused |

## Verification
The bench builds the block with FIFO_BYTES set to 256 and THR_W left at 6. A 64-word buffer can be filled to capacity in a few dozen writes, so the dropped write past the end is reachable. So is the refusal of a length one above the 240-byte limit, and the completion cap, where the largest length with CRC stored needs more bytes than the buffer holds. Threshold codes 0 to 3 give trigger points of 4 to 100 bytes, all below capacity. This lets random frames with random length, padding, CRC mode and back-pressure cross both the threshold and the completion point on either side.

// File: rtl/enet_tx_pkg.sv
package enet_tx_pkg;
  localparam int PREFIX_BYTES   = 2;
  localparam int HDR_BYTES      = 14;
  localparam int CRC_BYTES      = 4;
  localparam int MIN_FRAME      = 60;
  localparam int BYTES_PER_WORD = 4;
  localparam int THR_STEP       = 32;
  localparam int THR_BASE       = 4;
endpackage

// File: rtl/txa_store.sv
module txa_store #(
  parameter int FIFO_BYTES = 2048
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [$clog2(FIFO_BYTES)-3:0] waddr,
  input  logic [31:0]                   wdata,
  input  logic [$clog2(FIFO_BYTES)-1:0] raddr,
  output logic [7:0]                    rbyte
);
  localparam int WORDS = FIFO_BYTES / enet_tx_pkg::BYTES_PER_WORD;

  logic [31:0] mem [WORDS];
  logic [31:0] rword;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rword = mem[raddr[$clog2(FIFO_BYTES)-1:2]];
    rbyte = rword[{raddr[1:0], 3'b000} +: 8];
  end
endmodule

// File: rtl/txa_ctrl.sv
module txa_ctrl
  import enet_tx_pkg::*;
#(
  parameter int FIFO_BYTES = 2048,
  parameter int THR_W      = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  input  logic [31:0]                   wr_data,
  input  logic                          thr_we,
  input  logic [THR_W-1:0]              thr_in,
  input  logic                          crc_auto,
  input  logic                          tx_req,
  input  logic                          flush,
  input  logic                          busy,
  input  logic                          done,
  output logic                          mem_we,
  output logic [$clog2(FIFO_BYTES)-3:0] mem_waddr,
  output logic                          start,
  output logic [15:0]                   len_o,
  output logic [$clog2(FIFO_BYTES):0]   fill_o,
  output logic                          tx_err_o,
  output logic                          tx_empty_o
);
  localparam int CNT_W   = $clog2(FIFO_BYTES) + 1;
  localparam int MAX_LEN = FIFO_BYTES - PREFIX_BYTES - HDR_BYTES;
  localparam logic [THR_W-1:0] THR_OFF = {THR_W{1'b1}};

  logic [CNT_W-1:0] fill_q;
  logic [15:0]      len_q;
  logic [THR_W-1:0] thr_q;
  logic             err_q, empty_q;

  logic        wr_open, first, len_bad, room, accept, thr_hit, complete;
  logic [31:0] need_raw, need;

  always_comb begin
    first    = (fill_q == '0);
    len_bad  = first && (32'(wr_data[15:0]) > 32'(MAX_LEN));
    room     = (32'(fill_q) + 32'(BYTES_PER_WORD)) <= 32'(FIFO_BYTES);
    need_raw = 32'(len_q) + 32'(PREFIX_BYTES + HDR_BYTES)
             + (crc_auto ? 32'd0 : 32'(CRC_BYTES));
    need     = (need_raw > 32'(FIFO_BYTES)) ? 32'(FIFO_BYTES) : need_raw;
    thr_hit  = (thr_q != THR_OFF)
            && (32'(fill_q) >= 32'(thr_q) * 32'(THR_STEP) + 32'(THR_BASE));
    complete = 32'(fill_q) >= need;
    start    = !busy && !first && !flush && (tx_req || (thr_hit && complete));
    wr_open  = wr_valid && !busy && !flush && !start;
    accept   = wr_open && !len_bad && room;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q  <= '0;
      len_q   <= '0;
      thr_q   <= THR_OFF;
      err_q   <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      err_q   <= wr_open && len_bad;
      empty_q <= done;
      if (thr_we) thr_q <= thr_in;
      if (accept && first) len_q <= wr_data[15:0];
      if (done)                fill_q <= '0;
      else if (flush && !busy) fill_q <= '0;
      else if (accept)         fill_q <= fill_q + CNT_W'(BYTES_PER_WORD);
    end
  end

  assign mem_we     = accept;
  assign mem_waddr  = fill_q[CNT_W-2:2];
  assign len_o      = len_q;
  assign fill_o     = fill_q;
  assign tx_err_o   = err_q;
  assign tx_empty_o = empty_q;
endmodule

// File: rtl/txa_stream.sv
module txa_stream
  import enet_tx_pkg::*;
#(
  parameter int FIFO_BYTES = 2048
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [15:0]                   len,
  input  logic                          pad_en,
  input  logic [7:0]                    rbyte,
  output logic [$clog2(FIFO_BYTES)-1:0] raddr,
  output logic                          m_valid,
  output logic [7:0]                    m_data,
  output logic                          m_last,
  input  logic                          m_ready,
  output logic                          busy,
  output logic                          done
);
  localparam int BA_W = $clog2(FIFO_BYTES);
  localparam int FR_W = 17;
  localparam logic [FR_W-1:0] MAX_FRAME = FR_W'(FIFO_BYTES - PREFIX_BYTES);

  logic            sending_q;
  logic [FR_W-1:0] idx_q, plen_q, flen_q;
  logic [FR_W-1:0] base, padded, capped;

  always_comb begin
    base   = {1'b0, len} + FR_W'(HDR_BYTES);
    padded = (pad_en && base < FR_W'(MIN_FRAME)) ? FR_W'(MIN_FRAME) : base;
    capped = (padded > MAX_FRAME) ? MAX_FRAME : padded;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending_q <= 1'b0;
      idx_q     <= '0;
      plen_q    <= '0;
      flen_q    <= '0;
    end else if (start && !sending_q) begin
      sending_q <= 1'b1;
      idx_q     <= '0;
      plen_q    <= base;
      flen_q    <= capped;
    end else if (sending_q && m_ready) begin
      if (m_last) sending_q <= 1'b0;
      idx_q <= idx_q + FR_W'(1);
    end
  end

  assign raddr   = BA_W'(idx_q + FR_W'(PREFIX_BYTES));
  assign m_valid = sending_q;
  assign m_data  = (idx_q < plen_q) ? rbyte : 8'h00;
  assign m_last  = sending_q && (idx_q == flen_q - FR_W'(1));
  assign busy    = sending_q;
  assign done    = sending_q && m_ready && m_last;
endmodule

// File: rtl/enet_tx_assembler.sv
module enet_tx_assembler #(
  parameter int FIFO_BYTES = 2048,
  parameter int THR_W      = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [31:0]      wr_data_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             crc_auto_i,
  input  logic             pad_en_i,
  input  logic             tx_req_i,
  input  logic             flush_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic             tx_last_o,
  input  logic             tx_ready_i,
  output logic             tx_busy_o,
  output logic             tx_empty_o,
  output logic             tx_err_o
);
  localparam int BA_W  = $clog2(FIFO_BYTES);
  localparam int CNT_W = BA_W + 1;

  logic            mem_we, start, busy, done;
  logic [BA_W-3:0] mem_waddr;
  logic [BA_W-1:0] raddr;
  logic [7:0]      rbyte;
  logic [15:0]     len;
  logic [CNT_W-1:0] fill_w;

  txa_ctrl #(.FIFO_BYTES(FIFO_BYTES), .THR_W(THR_W)) u_ctrl (
    .clk(clk_i), .rst_n(rst_ni), .wr_valid(wr_valid_i), .wr_data(wr_data_i),
    .thr_we(thr_we_i), .thr_in(thr_i), .crc_auto(crc_auto_i), .tx_req(tx_req_i),
    .flush(flush_i), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .start(start), .len_o(len), .fill_o(fill_w),
    .tx_err_o(tx_err_o), .tx_empty_o(tx_empty_o)
  );

  txa_store #(.FIFO_BYTES(FIFO_BYTES)) u_store (
    .clk(clk_i), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data_i),
    .raddr(raddr), .rbyte(rbyte)
  );

  txa_stream #(.FIFO_BYTES(FIFO_BYTES)) u_stream (
    .clk(clk_i), .rst_n(rst_ni), .start(start), .len(len), .pad_en(pad_en_i),
    .rbyte(rbyte), .raddr(raddr), .m_valid(tx_valid_o), .m_data(tx_data_o),
    .m_last(tx_last_o), .m_ready(tx_ready_i), .busy(busy), .done(done)
  );

  assign tx_busy_o = busy;
endmodule

// File: rtl/enet_tx_assembler_chk.sv
module enet_tx_assembler_chk #(
  parameter int FIFO_BYTES = 2048
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tx_valid,
  input logic [7:0]                  tx_data,
  input logic                        tx_last,
  input logic                        tx_ready,
  input logic                        tx_busy,
  input logic                        tx_empty,
  input logic                        tx_err,
  input logic [$clog2(FIFO_BYTES):0] fill
);
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill) <= 32'(FIFO_BYTES));

  p_err_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (fill == '0));

  p_clear_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (tx_empty && fill == '0 && !tx_valid));

  p_empty_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> !tx_empty);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !(tx_valid && tx_ready && tx_last)) |=> $stable(fill));
endmodule

bind enet_tx_assembler enet_tx_assembler_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .tx_valid(tx_valid_o), .tx_data(tx_data_o),
  .tx_last(tx_last_o), .tx_ready(tx_ready_i), .tx_busy(tx_busy_o),
  .tx_empty(tx_empty_o), .tx_err(tx_err_o), .fill(fill_w)
);

// File: tb/enet_tx_assembler_bench.sv
module enet_tx_assembler_bench;
  localparam int FB = 256;
  localparam int MAXL = FB - 16;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, thr_we = 0, crc_auto = 1, pad_en = 0, tx_req = 0, flush = 0;
  logic tx_ready = 0;
  logic [31:0] wr_data = 0;
  logic [5:0]  thr = 0;
  logic tx_valid, tx_last, tx_busy, tx_empty, tx_err;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;
  logic [7:0] mb [FB];
  int m_fill = 0, m_len = 0, m_thr = 63;
  bit done_flag = 0;

  always #4 clk = ~clk;

  enet_tx_assembler #(.FIFO_BYTES(FB), .THR_W(6)) u_enet_tx_assembler (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .thr_we_i(thr_we), .thr_i(thr), .crc_auto_i(crc_auto), .pad_en_i(pad_en),
    .tx_req_i(tx_req), .flush_i(flush), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_last_o(tx_last), .tx_ready_i(tx_ready), .tx_busy_o(tx_busy),
    .tx_empty_o(tx_empty), .tx_err_o(tx_err)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_start();
    int need;
    need = m_len + 16 + (crc_auto ? 0 : 4);
    if (need > FB) need = FB;
    return (m_thr != 63) && (m_fill != 0) && (m_fill >= 32 * m_thr + 4) && (m_fill >= need);
  endfunction

  function automatic int exp_flen(bit pad);
    int f;
    f = m_len + 14;
    if (pad && f < 60) f = 60;
    if (f > FB - 2) f = FB - 2;
    return f;
  endfunction

  task automatic set_thr(int t);
    @(negedge clk); thr = 6'(t); thr_we = 1;
    @(negedge clk); thr_we = 0;
    m_thr = t;
  endtask

  // drives one word; updates the model if model=1
  task automatic wr_word(logic [31:0] w, bit model);
    @(negedge clk); wr_valid = 1; wr_data = w;
    @(negedge clk); wr_valid = 0;
    if (model) begin
      if (m_fill == 0 && int'(w[15:0]) > MAXL) begin
      end else if (m_fill + 4 <= FB) begin
        if (m_fill == 0) m_len = int'(w[15:0]);
        for (int k = 0; k < 4; k++) mb[m_fill + k] = w[8*k +: 8];
        m_fill += 4;
      end
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  // collect a frame; ready random when rnd=1; extra=1 pokes inputs while busy (R11)
  task automatic collect(bit pad, bit rnd, bit extra);
    int i = 0, fl, guard = 0;
    bit held = 0;
    logic [7:0] hd = 0;
    logic hl = 0;
    fl = exp_flen(pad);
    while (guard < 5000) begin
      @(negedge clk);
      guard++;
      if (extra && guard < 4) begin
        wr_valid = 1; wr_data = $urandom; tx_req = 1; flush = 1; tx_ready = 0;
      end else begin
        wr_valid = 0; tx_req = 0; flush = 0;
        tx_ready = rnd ? 1'($urandom % 2) : 1'b1;
      end
      #1;
      if (held) begin
        chk(tx_valid && tx_data == hd && tx_last == hl, "R10 hold", int'(tx_data), int'(hd));
        held = 0;
      end
      if (tx_valid && !tx_ready) begin
        held = 1; hd = tx_data; hl = tx_last;
      end
      if (tx_valid && tx_ready) begin
        int eb;
        eb = (i < m_len + 14) ? int'(mb[i + 2]) : 0;
        chk(int'(tx_data) == eb, (i < m_len + 14) ? "R6 byte" : "R7 pad byte", int'(tx_data), eb);
        chk(tx_last == (i == fl - 1), "R10 last", int'(tx_last), int'(i == fl - 1));
        i++;
        if (tx_last || i >= fl) break;
      end
    end
    chk(i == fl, "R6 frame length", i, fl);
    @(negedge clk); tx_ready = 0;
    chk(tx_empty == 1 && tx_busy == 0, "R8 empty event", int'(tx_empty), 1);
    @(negedge clk);
    chk(tx_empty == 0, "R8 single pulse", int'(tx_empty), 0);
    m_fill = 0;
  endtask

  // fill a frame word by word, checking start timing, then send it
  task automatic run_frame(int len, bit pad, bit crc, int t, bit rnd);
    bit started = 0;
    set_thr(t);
    pad_en = pad; crc_auto = crc;
    wr_word({16'($urandom), 16'(len)}, 1);
    while (!started) begin
      bit pred;
      pred = exp_start();
      @(negedge clk);
      chk(tx_busy == pred, "R4 auto start timing", int'(tx_busy), int'(pred));
      started = tx_busy;
      if (!started) begin
        int need;
        need = m_len + 16 + (crc ? 0 : 4);
        if (need > FB) need = FB;
        if (t == 63 && m_fill >= need || m_fill >= FB) begin
          pulse_req();
          chk(tx_busy == 1, "R5 manual start", int'(tx_busy), 1);
          started = 1;
        end else begin
          wr_word($urandom, 1);
        end
      end
    end
    collect(pad, rnd, 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done_flag) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(!tx_valid && !tx_busy && !tx_empty && !tx_err, "R12 reset outputs",
        int'({tx_valid, tx_busy, tx_empty, tx_err}), 0);

    // R12/R4: threshold disabled after reset, complete frame does not send
    crc_auto = 1; pad_en = 1;
    wr_word({16'hABCD, 16'd4}, 1);
    for (int w = 0; w < 5; w++) wr_word($urandom, 1);
    repeat (4) @(negedge clk);
    chk(tx_busy == 0, "R12 auto send disabled", int'(tx_busy), 0);
    pulse_req();
    chk(tx_busy == 1, "R5 manual start", int'(tx_busy), 1);
    collect(1, 0, 0);   // R7: 18 bytes padded to 60

    // R3 cap: len at limit with CRC stored needs more than capacity
    run_frame(MAXL, 0, 0, 0, 1);

    // R4 threshold above completion point
    run_frame(10, 0, 1, 2, 1);

    // R2 refused length
    set_thr(63);
    wr_word({16'h0, 16'(MAXL + 1)}, 1);
    chk(tx_err == 1, "R2 error event", int'(tx_err), 1);
    @(negedge clk);
    chk(tx_err == 0, "R2 single pulse", int'(tx_err), 0);
    pulse_req();
    chk(tx_busy == 0, "R2 nothing stored", int'(tx_busy), 0);

    // R1 overflow: 65th word dropped
    crc_auto = 1; pad_en = 0;
    wr_word({16'h1234, 16'd200}, 1);
    for (int w = 0; w < 64; w++) wr_word($urandom, 1);
    chk(m_fill == FB, "R1 model full", m_fill, FB);
    pulse_req();
    chk(tx_busy == 1, "R5 manual start", int'(tx_busy), 1);
    collect(0, 1, 0);

    // R9 flush
    wr_word({16'h0, 16'd20}, 1);
    wr_word($urandom, 1); wr_word($urandom, 1);
    pulse_flush();
    m_fill = 0;
    pulse_req();
    chk(tx_busy == 0, "R9 flush empties", int'(tx_busy), 0);
    run_frame(20, 0, 1, 63, 0);

    // R11 inputs ignored while sending
    crc_auto = 1; pad_en = 0;
    wr_word({16'h0, 16'd30}, 1);
    for (int w = 0; w < 12; w++) wr_word($urandom, 1);
    pulse_req();
    chk(tx_busy == 1, "R5 manual start", int'(tx_busy), 1);
    collect(0, 0, 1);
    pulse_req();
    chk(tx_busy == 0, "R11 writes while busy dropped", int'(tx_busy), 0);

    // random frames
    for (int n = 0; n < 40; n++) begin
      int t;
      t = int'($urandom % 5);
      if (t == 4) t = 63;
      run_frame(int'($urandom % 101), 1'($urandom % 2), 1'($urandom % 2), t, 1);
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule